// File: doc/BRIEF.md
# Vectored Interrupt Entry and Return Sequencer

This block steps a processor core through the entry into a vectored interrupt and the return from it. When a request is accepted, it captures the current program counter (20 bits), status byte and stack pointer. It writes a four-byte frame onto a stack that grows downward, and then fetches a 16-bit handler address, two bytes with the low byte first, from a table slot picked by the source index. At the end it hands the core a new program counter whose upper four bits are always zero, so every handler lies in the low 64K base area. The same strobe also loads a status byte with the interrupt-enable bit cleared and a stack pointer lowered by four.

A return command pops the four frame bytes in the reverse of the push order. It reloads the program counter, the status byte and the stack pointer, and marks completion with a one-cycle done pulse. A flag sampled with the return command selects the flavour used to leave break-instruction and operand-error entries; both flavours restore the same state. Memory access uses a byte-wide port with separate read and write strobes. Read data is returned one cycle after the read strobe.

Top module: `irq_vec_seq`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, busy, mem_we, mem_re, pc_load, psw_load, sp_load, done and done_brk are all 0. A reset in the middle of a sequence abandons that sequence.
- R2: A request sampled while idle raises busy in the next cycle. Busy stays high up to and including the load cycle and is low in the cycle after the load.
- R3: In the four cycles after acceptance of irq_req, the block writes one byte per cycle to addresses {4'h0, SP-1}, {4'h0, SP-2}, {4'h0, SP-3} and {4'h0, SP-4}. The data, in that order, is PSW, {4'h0, PC[19:16]}, PC[15:8] and PC[7:0].
- R4: In cycles 5 and 6 after acceptance, the block reads VEC_BASE + 2*irq_src (the low byte) and then VEC_BASE + 2*irq_src + 1 (the high byte). Each byte appears on mem_rdata in the cycle after its read strobe.
- R5: In cycle 8 after acceptance, pc_load, psw_load and sp_load pulse for one cycle. At that point pc_new = {4'h0, high byte, low byte}, psw_new equals the saved PSW with bit 7 (the interrupt enable) cleared, sp_new = SP-4, and done stays 0.
- R6: In the four cycles after acceptance of ret_req, the block reads {4'h0, SP}, SP+1, SP+2 and SP+3, one per cycle, and writes nothing.
- R7: In cycle 6 after acceptance of a return, pc_load, psw_load, sp_load and done pulse together for one cycle. sp_new = SP+4 and pc_new = {byte[SP+2][3:0], byte[SP+1], byte[SP]}.
- R8: done_brk equals the ret_brk value sampled with ret_req and is only high together with done. Both flavours restore the same values.
- R9: When irq_req and ret_req are sampled high together in idle, the entry sequence runs.
- R10: Requests sampled while busy are ignored. They change neither the addresses nor the results, and they do not start a new sequence.
- R11: An entry followed by a return, with the stack pointer produced by the entry, restores psw_new to the PSW that was saved and pc_new to the interrupted PC.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| irq_req | input | 1 | Accepted interrupt request |
| irq_src | input | 5 | Source index selecting the table slot |
| ret_req | input | 1 | Return command |
| ret_brk | input | 1 | Return flavour for break/operand-error entries |
| cur_pc | input | 20 | Current program counter |
| cur_psw | input | 8 | Current status byte, bit 7 = interrupt enable |
| cur_sp | input | 16 | Current stack pointer |
| busy | output | 1 | Sequence in progress |
| mem_addr | output | 20 | Byte address |
| mem_we | output | 1 | Write strobe |
| mem_wdata | output | 8 | Write data |
| mem_re | output | 1 | Read strobe |
| mem_rdata | input | 8 | Read data, valid the cycle after mem_re |
| pc_load | output | 1 | Load pc_new into the program counter |
| pc_new | output | 20 | New program counter |
| psw_load | output | 1 | Load psw_new |
| psw_new | output | 8 | New status byte |
| sp_load | output | 1 | Load sp_new |
| sp_new | output | 16 | New stack pointer |
| done | output | 1 | One-cycle pulse when a return completes |
| done_brk | output | 1 | The completed return was the break flavour |

## Verification
Counting from the clock edge that samples the request, the writes are due in cycles 1 to 4 and the table reads in cycles 5 and 6. The entry load falls in cycle 8 and busy is low again in cycle 9. For a return, the reads fall in cycles 1 to 4, the load and done in cycle 6, and the idle state in cycle 7. The bench drives inputs on falling edges and samples each output at the falling edge of the exact cycle in which that result is due. It compares the address and data every cycle rather than only the final values, so a skipped or reordered byte is caught.

// File: rtl/irq_vec_pkg.sv
package irq_vec_pkg;
    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_PUSH  = 3'd1,
        ST_VEC   = 3'd2,
        ST_ELOAD = 3'd3,
        ST_POP   = 3'd4,
        ST_RLOAD = 3'd5
    } seq_state_e;

    localparam int BYTE_W      = 8;
    localparam int FRAME_BYTES = 4;
    localparam int VEC_BYTES   = 2;
endpackage

// File: rtl/irq_vec_frame.sv
// Selects the byte pushed in each slot of the saved frame.
module irq_vec_frame #(
    parameter int ADDR_W = 20,
    parameter int BASE_W = 16,
    parameter int PSW_W  = 8
) (
    input  logic [1:0]        slot,
    input  logic [ADDR_W-1:0] pc,
    input  logic [PSW_W-1:0]  psw,
    output logic [7:0]        byte_o
);
    localparam int HI_W = ADDR_W - BASE_W;

    always_comb begin
        unique case (slot)
            2'd0:    byte_o = psw;
            2'd1:    byte_o = {{(8-HI_W){1'b0}}, pc[ADDR_W-1:BASE_W]};
            2'd2:    byte_o = pc[15:8];
            default: byte_o = pc[7:0];
        endcase
    end
endmodule

// File: rtl/irq_vec_tbl.sv
// Table slot address: base plus two bytes per source, plus the byte select.
module irq_vec_tbl #(
    parameter int              ADDR_W   = 20,
    parameter int              SRC_W    = 5,
    parameter logic [ADDR_W-1:0] VEC_BASE = 20'h00040
) (
    input  logic [SRC_W-1:0]  src,
    input  logic              hi_sel,
    output logic [ADDR_W-1:0] addr
);
    always_comb begin
        addr = VEC_BASE + (ADDR_W'(src) << 1) + ADDR_W'(hi_sel);
    end
endmodule

// File: rtl/irq_vec_unpack.sv
// Builds the loaded PC/PSW from captured bytes for entry or return.
module irq_vec_unpack #(
    parameter int ADDR_W = 20,
    parameter int BASE_W = 16,
    parameter int PSW_W  = 8,
    parameter int IE_BIT = 7
) (
    input  logic                is_ret,
    input  logic [3:0][7:0]     cap,
    input  logic [PSW_W-1:0]    saved_psw,
    output logic [ADDR_W-1:0]   pc_o,
    output logic [PSW_W-1:0]    psw_o
);
    localparam int HI_W = ADDR_W - BASE_W;

    always_comb begin
        if (is_ret) begin
            pc_o  = {cap[2][HI_W-1:0], cap[1], cap[0]};
            psw_o = cap[3];
        end else begin
            pc_o          = {{HI_W{1'b0}}, cap[1], cap[0]};
            psw_o         = saved_psw;
            psw_o[IE_BIT] = 1'b0;
        end
    end
endmodule

// File: rtl/irq_vec_seq.sv
module irq_vec_seq
    import irq_vec_pkg::*;
#(
    parameter int                ADDR_W   = 20,
    parameter int                BASE_W   = 16,
    parameter int                PSW_W    = 8,
    parameter int                SRC_W    = 5,
    parameter int                IE_BIT   = 7,
    parameter logic [ADDR_W-1:0] VEC_BASE = 20'h00040
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              irq_req,
    input  logic [SRC_W-1:0]  irq_src,
    input  logic              ret_req,
    input  logic              ret_brk,
    input  logic [ADDR_W-1:0] cur_pc,
    input  logic [PSW_W-1:0]  cur_psw,
    input  logic [BASE_W-1:0] cur_sp,
    output logic              busy,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_we,
    output logic [7:0]        mem_wdata,
    output logic              mem_re,
    input  logic [7:0]        mem_rdata,
    output logic              pc_load,
    output logic [ADDR_W-1:0] pc_new,
    output logic              psw_load,
    output logic [PSW_W-1:0]  psw_new,
    output logic              sp_load,
    output logic [BASE_W-1:0] sp_new,
    output logic              done,
    output logic              done_brk
);
    localparam int HI_W     = ADDR_W - BASE_W;
    localparam int IDX_W    = 3;
    localparam logic [IDX_W-1:0] PUSH_LAST = IDX_W'(FRAME_BYTES - 1);
    localparam logic [IDX_W-1:0] VEC_LAST  = IDX_W'(VEC_BYTES);
    localparam logic [IDX_W-1:0] POP_LAST  = IDX_W'(FRAME_BYTES);

    typedef struct packed {
        seq_state_e                            state;
        logic [IDX_W-1:0]                      idx;
        logic [SRC_W-1:0]                      src;
        logic [ADDR_W-1:0]                     pc;
        logic [PSW_W-1:0]                      psw;
        logic [BASE_W-1:0]                     sp;
        logic                                  brk;
        logic [FRAME_BYTES-1:0][BYTE_W-1:0]    cap;
    } seq_regs_t;

    seq_regs_t         r_d, r_q;
    logic [7:0]        frame_byte;
    logic [ADDR_W-1:0] tbl_addr;
    logic [ADDR_W-1:0] unpack_pc;
    logic [PSW_W-1:0]  unpack_psw;
    logic [1:0]        cap_sel;

    irq_vec_frame #(.ADDR_W(ADDR_W), .BASE_W(BASE_W), .PSW_W(PSW_W)) frame_i (
        .slot   (r_q.idx[1:0]),
        .pc     (r_q.pc),
        .psw    (r_q.psw),
        .byte_o (frame_byte)
    );

    irq_vec_tbl #(.ADDR_W(ADDR_W), .SRC_W(SRC_W), .VEC_BASE(VEC_BASE)) tbl_i (
        .src    (r_q.src),
        .hi_sel (r_q.idx[0]),
        .addr   (tbl_addr)
    );

    irq_vec_unpack #(.ADDR_W(ADDR_W), .BASE_W(BASE_W), .PSW_W(PSW_W), .IE_BIT(IE_BIT)) unpack_i (
        .is_ret    (r_q.state == ST_RLOAD),
        .cap       (r_q.cap),
        .saved_psw (r_q.psw),
        .pc_o      (unpack_pc),
        .psw_o     (unpack_psw)
    );

    assign cap_sel = 2'(r_q.idx - IDX_W'(1));

    // Next-state computation
    always_comb begin
        r_d = r_q;
        unique case (r_q.state)
            ST_IDLE: begin
                if (irq_req) begin
                    r_d.state = ST_PUSH;
                    r_d.idx   = '0;
                    r_d.src   = irq_src;
                    r_d.pc    = cur_pc;
                    r_d.psw   = cur_psw;
                    r_d.sp    = cur_sp;
                end else if (ret_req) begin
                    r_d.state = ST_POP;
                    r_d.idx   = '0;
                    r_d.sp    = cur_sp;
                    r_d.brk   = ret_brk;
                end
            end
            ST_PUSH: begin
                if (r_q.idx == PUSH_LAST) begin
                    r_d.state = ST_VEC;
                    r_d.idx   = '0;
                end else begin
                    r_d.idx = r_q.idx + IDX_W'(1);
                end
            end
            ST_VEC: begin
                if (r_q.idx != '0) r_d.cap[cap_sel] = mem_rdata;
                if (r_q.idx == VEC_LAST) begin
                    r_d.state = ST_ELOAD;
                    r_d.idx   = '0;
                end else begin
                    r_d.idx = r_q.idx + IDX_W'(1);
                end
            end
            ST_POP: begin
                if (r_q.idx != '0) r_d.cap[cap_sel] = mem_rdata;
                if (r_q.idx == POP_LAST) begin
                    r_d.state = ST_RLOAD;
                    r_d.idx   = '0;
                end else begin
                    r_d.idx = r_q.idx + IDX_W'(1);
                end
            end
            default: begin
                r_d.state = ST_IDLE;
                r_d.idx   = '0;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    // Outputs decoded from registered state
    always_comb begin
        busy      = (r_q.state != ST_IDLE);
        mem_we    = (r_q.state == ST_PUSH);
        mem_wdata = mem_we ? frame_byte : '0;
        mem_re    = ((r_q.state == ST_VEC) && (r_q.idx < VEC_LAST)) ||
                    ((r_q.state == ST_POP) && (r_q.idx < POP_LAST));
        unique case (r_q.state)
            ST_PUSH: mem_addr = {{HI_W{1'b0}}, r_q.sp - BASE_W'(r_q.idx) - BASE_W'(1)};
            ST_VEC:  mem_addr = mem_re ? tbl_addr : '0;
            ST_POP:  mem_addr = mem_re ? {{HI_W{1'b0}}, r_q.sp + BASE_W'(r_q.idx)} : '0;
            default: mem_addr = '0;
        endcase
        pc_load  = (r_q.state == ST_ELOAD) || (r_q.state == ST_RLOAD);
        psw_load = pc_load;
        sp_load  = pc_load;
        pc_new   = pc_load ? unpack_pc : '0;
        psw_new  = pc_load ? unpack_psw : '0;
        if (r_q.state == ST_ELOAD)      sp_new = r_q.sp - BASE_W'(FRAME_BYTES);
        else if (r_q.state == ST_RLOAD) sp_new = r_q.sp + BASE_W'(FRAME_BYTES);
        else                            sp_new = '0;
        done     = (r_q.state == ST_RLOAD);
        done_brk = done && r_q.brk;
    end
endmodule

// File: rtl/irq_vec_seq_chk.sv
module irq_vec_seq_chk #(
    parameter int ADDR_W = 20,
    parameter int BASE_W = 16,
    parameter int PSW_W  = 8,
    parameter int IE_BIT = 7
) (
    input logic              clk,
    input logic              rst_n,
    input logic              irq_req,
    input logic              ret_req,
    input logic              busy,
    input logic              mem_we,
    input logic              mem_re,
    input logic              pc_load,
    input logic [ADDR_W-1:0] pc_new,
    input logic              psw_load,
    input logic [PSW_W-1:0]  psw_new,
    input logic              sp_load,
    input logic              done,
    input logic              done_brk
);
    AST_BUSY_NEEDS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(irq_req || ret_req)); // R2
    AST_LOAD_ENDS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        pc_load |=> !busy); // R2
    AST_RW_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_we && mem_re)); // R3
    AST_ENTRY_BASE_AREA: assert property (@(posedge clk) disable iff (!rst_n)
        (pc_load && !done) |-> (pc_new[ADDR_W-1:BASE_W] == '0)); // R5
    AST_ENTRY_IE_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (pc_load && !done) |-> !psw_new[IE_BIT]); // R5
    AST_LOAD_TOGETHER: assert property (@(posedge clk) disable iff (!rst_n)
        pc_load |-> (psw_load && sp_load)); // R7
    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R7
    AST_DONE_WITH_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> pc_load); // R7
    AST_BRK_QUALIFIED: assert property (@(posedge clk) disable iff (!rst_n)
        done_brk |-> done); // R8
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !(mem_we || mem_re || pc_load)); // R10
endmodule

bind irq_vec_seq irq_vec_seq_chk #(
    .ADDR_W(ADDR_W), .BASE_W(BASE_W), .PSW_W(PSW_W), .IE_BIT(IE_BIT)
) chk_i (
    .clk(clk), .rst_n(rst_n), .irq_req(irq_req), .ret_req(ret_req),
    .busy(busy), .mem_we(mem_we), .mem_re(mem_re), .pc_load(pc_load),
    .pc_new(pc_new), .psw_load(psw_load), .psw_new(psw_new),
    .sp_load(sp_load), .done(done), .done_brk(done_brk)
);

// File: tb/irq_vec_seq_tb_top.sv
`timescale 1ns/1ps
module irq_vec_seq_tb_top;
    localparam logic [19:0] VEC_BASE = 20'h00040;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        irq_req = 1'b0;
    logic [4:0]  irq_src = '0;
    logic        ret_req = 1'b0;
    logic        ret_brk = 1'b0;
    logic [19:0] cur_pc = '0;
    logic [7:0]  cur_psw = '0;
    logic [15:0] cur_sp = '0;
    logic        busy, mem_we, mem_re, pc_load, psw_load, sp_load, done, done_brk;
    logic [19:0] mem_addr, pc_new;
    logic [7:0]  mem_wdata, mem_rdata, psw_new;
    logic [15:0] sp_new;

    logic        pre_we = 1'b0;
    logic [11:0] pre_a = '0;
    logic [7:0]  pre_d = '0;
    logic [7:0]  mem [4096];

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    irq_vec_seq #(.VEC_BASE(VEC_BASE)) dut_i (
        .clk(clk), .rst_n(rst_n), .irq_req(irq_req), .irq_src(irq_src),
        .ret_req(ret_req), .ret_brk(ret_brk), .cur_pc(cur_pc), .cur_psw(cur_psw),
        .cur_sp(cur_sp), .busy(busy), .mem_addr(mem_addr), .mem_we(mem_we),
        .mem_wdata(mem_wdata), .mem_re(mem_re), .mem_rdata(mem_rdata),
        .pc_load(pc_load), .pc_new(pc_new), .psw_load(psw_load), .psw_new(psw_new),
        .sp_load(sp_load), .sp_new(sp_new), .done(done), .done_brk(done_brk)
    );

    // Behavioural byte memory, one-cycle read latency
    always @(posedge clk) begin
        if (mem_we)      mem[mem_addr[11:0]] <= mem_wdata;
        else if (pre_we) mem[pre_a] <= pre_d;
        if (mem_re)      mem_rdata <= mem[mem_addr[11:0]];
    end

    // Stimulus table: {src, pc, psw, sp, vector}
    localparam int NV = 5;
    localparam logic [64:0] VECS [NV] = '{
        {5'd0,  20'h12345, 8'h83, 16'h0800, 16'h1A2B},
        {5'd31, 20'hF0000, 8'hFF, 16'h0A10, 16'hFFFF},
        {5'd7,  20'h00000, 8'h00, 16'h0C00, 16'h0000},
        {5'd12, 20'hABCDE, 8'h7F, 16'h0900, 16'h8001},
        {5'd3,  20'h5A5A5, 8'hC1, 16'h0E02, 16'h4321}
    };

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    function automatic logic [7:0] frame_exp(input int k, input logic [19:0] pc, input logic [7:0] psw);
        case (k)
            0: return psw;
            1: return {4'h0, pc[19:16]};
            2: return pc[15:8];
            default: return pc[7:0];
        endcase
    endfunction

    task automatic preload(input logic [11:0] a, input logic [7:0] d);
        @(negedge clk); pre_we = 1'b1; pre_a = a; pre_d = d;
        @(negedge clk); pre_we = 1'b0;
    endtask

    task automatic run_entry(input logic [4:0] s, input logic [19:0] pc, input logic [7:0] psw,
                             input logic [15:0] sp, input logic [15:0] vec,
                             input bit both, input bit disturb);
        logic [19:0] ta;
        ta = VEC_BASE + 20'({s, 1'b0});
        preload(ta[11:0], vec[7:0]);
        preload(ta[11:0] + 12'd1, vec[15:8]);
        @(negedge clk);
        irq_src = s; cur_pc = pc; cur_psw = psw; cur_sp = sp; irq_req = 1'b1; ret_req = both;
        @(negedge clk);                                   // cycle 1
        irq_req = 1'b0; ret_req = 1'b0;
        chk(busy, "R2 busy after accept", 32'(busy), 1);
        if (both) chk(mem_we && !mem_re, "R9 entry wins", 32'(mem_we), 1);
        if (disturb) begin irq_req = 1'b1; irq_src = ~s; ret_req = 1'b1; end
        for (int k = 0; k < 4; k++) begin
            chk(mem_we && !mem_re, "R3 write strobe", 32'({mem_we, mem_re}), 32'h2);
            chk(mem_addr == {4'h0, sp - 16'(k + 1)}, "R3 push address", 32'(mem_addr), 32'({4'h0, sp - 16'(k + 1)}));
            chk(mem_wdata == frame_exp(k, pc, psw), "R3 push data", 32'(mem_wdata), 32'(frame_exp(k, pc, psw)));
            @(negedge clk);
        end
        // cycle 5
        chk(mem_re && mem_addr == ta, "R4 low vector read", 32'(mem_addr), 32'(ta));
        @(negedge clk);                                   // cycle 6
        chk(mem_re && mem_addr == ta + 20'd1, "R4 high vector read", 32'(mem_addr), 32'(ta + 20'd1));
        @(negedge clk);                                   // cycle 7
        if (disturb) chk(busy && !pc_load, "R10 no early load", 32'(pc_load), 0);
        irq_req = 1'b0; ret_req = 1'b0;
        @(negedge clk);                                   // cycle 8
        chk(pc_load && psw_load && sp_load && !done, "R5 load strobes", 32'({pc_load, psw_load, sp_load, done}), 32'hE);
        chk(pc_new == {4'h0, vec}, "R5 branch pc", 32'(pc_new), 32'({4'h0, vec}));
        chk(psw_new == (psw & 8'h7F), "R5 psw IE cleared", 32'(psw_new), 32'(psw & 8'h7F));
        chk(sp_new == sp - 16'd4, "R5 stack pointer", 32'(sp_new), 32'(sp - 16'd4));
        @(negedge clk);                                   // cycle 9
        chk(!busy && !pc_load, "R2 busy released", 32'({busy, pc_load}), 0);
        if (disturb) begin
            @(negedge clk);
            chk(!busy && !mem_we && !mem_re, "R10 no sequence from busy request", 32'({busy, mem_we, mem_re}), 0);
        end
    endtask

    task automatic run_return(input logic [15:0] sp, input bit brk, input logic [19:0] pc_exp,
                              input logic [7:0] psw_exp);
        @(negedge clk);
        cur_sp = sp; ret_req = 1'b1; ret_brk = brk;
        @(negedge clk);                                   // cycle 1
        ret_req = 1'b0; ret_brk = 1'b0;
        for (int k = 0; k < 4; k++) begin
            chk(mem_re && !mem_we && mem_addr == {4'h0, sp + 16'(k)}, "R6 pop read",
                32'(mem_addr), 32'({4'h0, sp + 16'(k)}));
            @(negedge clk);
        end
        @(negedge clk);                                   // cycle 6
        chk(pc_load && psw_load && sp_load && done, "R7 return strobes", 32'({pc_load, psw_load, sp_load, done}), 32'hF);
        chk(sp_new == sp + 16'd4, "R7 stack pointer", 32'(sp_new), 32'(sp + 16'd4));
        chk(pc_new == pc_exp, "R11 restored pc", 32'(pc_new), 32'(pc_exp));
        chk(psw_new == psw_exp, "R11 restored psw", 32'(psw_new), 32'(psw_exp));
        chk(done_brk == brk, "R8 return flavour", 32'(done_brk), 32'(brk));
        @(negedge clk);                                   // cycle 7
        chk(!done && !busy && !done_brk, "R7 done single pulse", 32'({done, busy}), 0);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_bad++;
            n_chk++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        chk(!busy && !mem_we && !mem_re && !pc_load && !done, "R1 outputs in reset",
            32'({busy, mem_we, mem_re, pc_load, done}), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!busy && !psw_load && !sp_load && !done_brk, "R1 idle after reset",
            32'({busy, psw_load, sp_load, done_brk}), 0);

        // Table-driven entry/return round trips
        for (int i = 0; i < NV; i++) begin
            run_entry(VECS[i][64:60], VECS[i][59:40], VECS[i][39:32], VECS[i][31:16], VECS[i][15:0], 1'b0, 1'b0);
            run_return(VECS[i][31:16] - 16'd4, i[0], VECS[i][59:40], VECS[i][39:32]);
        end

        // Simultaneous requests: entry first, then return
        run_entry(5'd9, 20'h3C3C3, 8'h80, 16'h0B00, 16'h7E7E, 1'b1, 1'b0);
        run_return(16'h0AFC, 1'b1, 20'h3C3C3, 8'h80);

        // Requests while busy are ignored
        run_entry(5'd20, 20'h9F00F, 8'hA5, 16'h0D00, 16'h2468, 1'b0, 1'b1);

        // Reset mid-sequence abandons it
        @(negedge clk);
        irq_src = 5'd1; cur_pc = 20'h11111; cur_psw = 8'h80; cur_sp = 16'h0700; irq_req = 1'b1;
        @(negedge clk); irq_req = 1'b0;
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        chk(!busy && !mem_we && !mem_re, "R1 reset aborts", 32'({busy, mem_we, mem_re}), 0);
        rst_n = 1'b1;
        repeat (10) begin
            @(negedge clk);
            chk(!busy && !pc_load, "R1 stays idle", 32'({busy, pc_load}), 0);
        end

        finished = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule